// File: doc/BRIEF.md
# Block Transfer Repeat Unit

This unit sits at the end of every block-move, block-search and block-I/O instruction in a small processor core. When such an instruction finishes its data step, the core pulses `start` together with the instruction class, a flag that says whether the repeating form was decoded, the 16-bit count pair, the zero flag and the current program counter. The unit decides whether the instruction runs again.

If it does not run again, the unit asks for the next opcode fetch on the following cycle. Interrupts may be accepted at that fetch boundary. If it does run again, the unit runs a five-cycle rewind: idle, step the PC down, idle, step the PC down, then fetch. The fetch therefore lands on the same instruction. For the move and search classes, the rewind also loads the internal address scratch register with the PC value plus one.

The unit moves no data, computes no flags and does no memory access.

Top module: `blk_repeat_unit`

## Requirements
- R1: After reset, `busy`, `done` and `fetch` are low, and `pc_out` and `wz` are zero.
- R2: Class 0 (move, `op_class`=0) repeats exactly when the whole count `bc` is non-zero.
- R3: Class 1 (search, `op_class`=1) repeats exactly when `bc` is non-zero and `zero_flag` is low.
- R4: Classes 2 and 3 (I/O) repeat exactly when the upper byte of the count, `bc[15:8]`, is non-zero. The lower byte plays no part.
- R5: When `rep_form` is low, no class repeats, whatever the count and the flag.
- R6: On a repeat, `busy` is high for exactly the 5 cycles that follow the `start` cycle. `done` is high for one cycle, the first cycle after `busy` falls.
- R7: On a repeat, `pc_out` shows the latched PC for the first two busy cycles, PC-1 for the next two, and PC-2 in the last busy cycle and at `done`. Each step wraps modulo 2^16.
- R8: A repeat of class 0 or 1 loads `wz` with PC+1 (modulo 2^16), visible from the first busy cycle. A repeat of class 2 or 3, or a case with no repeat, leaves `wz` unchanged.
- R9: With no repeat, `fetch` pulses for one cycle in the cycle after `start`, and `pc_out` holds the PC that was given. With a repeat, `fetch` pulses together with `done`.
- R10: A `start` pulse that arrives while `busy` is high is ignored. It causes no extra `fetch`, and it leaves the running sequence's PC and `wz` untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | End-of-instruction evaluate strobe |
| op_class | input | 2 | 0 move, 1 search, 2 input, 3 output |
| rep_form | input | 1 | High when the repeating form was decoded |
| bc | input | 16 | Count pair; the upper byte is the I/O counter |
| zero_flag | input | 1 | Current zero flag |
| pc_in | input | 16 | Program counter at evaluation |
| busy | output | 1 | Rewind sequence in progress |
| done | output | 1 | One-cycle pulse at the end of a rewind |
| fetch | output | 1 | One-cycle request for the next opcode fetch |
| pc_out | output | 16 | Program counter as held and rewound by the unit |
| wz | output | 16 | Internal address scratch register |

## Verification
The assertions check four properties on every cycle. The PC never moves by more than one step per busy cycle. `done` only follows a busy period and always comes with `fetch`. `wz` holds PC+1 at the start of a move or search rewind. A strobe that arrives while busy does not disturb `wz`. Only the bench scenarios can show the rest. Those are the per-class repeat decisions, including the search flag and the I/O byte that ignores the low half, the exact five-cycle length and the PC trajectory, the wrap at both ends of the address space, and the absence of any extra fetch after a strobe that was ignored.

// File: rtl/blk_repeat_pkg.sv
package blk_repeat_pkg;

   typedef enum logic [1:0] {
      CLS_MOVE   = 2'd0,
      CLS_SEARCH = 2'd1,
      CLS_INPUT  = 2'd2,
      CLS_OUTPUT = 2'd3
   } blk_class_e;

   localparam int unsigned NUM_CLASSES = 4;

endpackage

// File: rtl/blk_repeat_cond.sv
module blk_repeat_cond
   import blk_repeat_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic [1:0]       op_class,
   input  logic             rep_form,
   input  logic [CNT_W-1:0] bc,
   input  logic             zero_flag,
   output logic             repeat_o,
   output logic             wz_upd_o
);

   localparam int unsigned HALF_W = CNT_W / 2;

   generate
      if (CNT_W < 2 || (CNT_W % 2) != 0) begin : g_bad_cnt
         $error("blk_repeat_cond: CNT_W must be even and at least 2");
      end
   endgenerate

   logic                    cnt_nz;
   logic                    hi_nz;
   logic [NUM_CLASSES-1:0]  cond_vec;

   assign cnt_nz = |bc;
   assign hi_nz  = |bc[CNT_W-1:HALF_W];

   // one continuation rule per instruction class
   for (genvar k = 0; k < NUM_CLASSES; k++) begin : g_cls
      if (k == int'(CLS_MOVE)) begin : g_move
         assign cond_vec[k] = cnt_nz;
      end else if (k == int'(CLS_SEARCH)) begin : g_search
         assign cond_vec[k] = cnt_nz & ~zero_flag;
      end else begin : g_io
         assign cond_vec[k] = hi_nz;
      end
   end

   assign repeat_o = rep_form & cond_vec[op_class];
   assign wz_upd_o = (op_class == CLS_MOVE) || (op_class == CLS_SEARCH);

endmodule

// File: rtl/blk_repeat_seq.sv
module blk_repeat_seq #(
   parameter int unsigned PC_W  = 16,
   parameter int unsigned STEPS = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            launch,
   input  logic            rep,
   input  logic [PC_W-1:0] pc_in,
   output logic            busy,
   output logic            done,
   output logic            fetch,
   output logic [PC_W-1:0] pc_out
);

   localparam int unsigned CW   = (STEPS > 1) ? $clog2(STEPS) : 1;
   localparam logic [CW-1:0] LAST = CW'(STEPS - 1);
   localparam logic [PC_W-1:0] ONE = PC_W'(1);

   generate
      if (STEPS < 3 || (STEPS % 2) == 0) begin : g_bad_steps
         $error("blk_repeat_seq: STEPS must be odd and at least 3");
      end
   endgenerate

   logic [CW-1:0]   cnt;
   logic [PC_W-1:0] pc_q;

   // even steps idle, odd steps rewind the PC by one, last step fetches
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         fetch <= 1'b0;
         cnt   <= '0;
         pc_q  <= '0;
      end else begin
         done  <= 1'b0;
         fetch <= 1'b0;
         if (launch) begin
            pc_q <= pc_in;
            cnt  <= '0;
            if (rep) begin
               busy <= 1'b1;
            end else begin
               fetch <= 1'b1;
            end
         end else if (busy) begin
            if (cnt == LAST) begin
               busy  <= 1'b0;
               done  <= 1'b1;
               fetch <= 1'b1;
               cnt   <= '0;
            end else begin
               cnt <= cnt + 1'b1;
               if (cnt[0]) begin
                  pc_q <= pc_q - ONE;
               end
            end
         end
      end
   end

   assign pc_out = pc_q;

   p_pc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |->
         ((pc_out == $past(pc_out)) || (pc_out == ($past(pc_out) - ONE))));

   p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy));

   p_fell_gives_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   p_done_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> fetch);

endmodule

// File: rtl/blk_repeat_unit.sv
module blk_repeat_unit #(
   parameter int unsigned PC_W  = 16,
   parameter int unsigned CNT_W = 16,
   parameter int unsigned STEPS = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [1:0]       op_class,
   input  logic             rep_form,
   input  logic [CNT_W-1:0] bc,
   input  logic             zero_flag,
   input  logic [PC_W-1:0]  pc_in,
   output logic             busy,
   output logic             done,
   output logic             fetch,
   output logic [PC_W-1:0]  pc_out,
   output logic [PC_W-1:0]  wz
);

   localparam logic [PC_W-1:0] ONE = PC_W'(1);

   logic rep_hit;
   logic wz_upd;
   logic launch;

   blk_repeat_cond #(.CNT_W(CNT_W)) u_cond (
      .op_class (op_class),
      .rep_form (rep_form),
      .bc       (bc),
      .zero_flag(zero_flag),
      .repeat_o (rep_hit),
      .wz_upd_o (wz_upd)
   );

   assign launch = start & ~busy;

   blk_repeat_seq #(.PC_W(PC_W), .STEPS(STEPS)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .launch(launch),
      .rep   (rep_hit),
      .pc_in (pc_in),
      .busy  (busy),
      .done  (done),
      .fetch (fetch),
      .pc_out(pc_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wz <= '0;
      end else if (launch && rep_hit && wz_upd) begin
         wz <= pc_in + ONE;
      end
   end

   p_wz_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && ($past(op_class) <= 2'd1)) |-> (wz == ($past(pc_in) + ONE)));

   p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (wz == $past(wz)));

endmodule

// File: tb/blk_repeat_unit_tb.sv
`timescale 1ns/1ps
module blk_repeat_unit_tb;

   typedef struct {
      int          cyc;
      logic [15:0] pc;
      logic [15:0] wz;
      logic        dn;
      string       req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op_class = 2'd0;
   logic        rep_form = 1'b0;
   logic [15:0] bc = 16'd0;
   logic        zero_flag = 1'b0;
   logic [15:0] pc_in = 16'd0;
   logic        busy, done, fetch;
   logic [15:0] pc_out, wz;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   logic [15:0] wz_m = 16'd0;
   exp_t sb[$];
   bit finished = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   blk_repeat_unit u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_class(op_class),
      .rep_form(rep_form), .bc(bc), .zero_flag(zero_flag), .pc_in(pc_in),
      .busy(busy), .done(done), .fetch(fetch), .pc_out(pc_out), .wz(wz)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // monitor: pops one expected item per fetch pulse
   initial begin
      forever begin
         @(negedge clk);
         if (fetch) begin
            if (sb.size() == 0) begin
               chk(1'b0, "R10 unexpected fetch", 1, 0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               chk(cyc == e.cyc, {e.req, " fetch cycle"}, cyc, e.cyc);
               chk(pc_out == e.pc, {e.req, " pc at fetch"}, pc_out, e.pc);
               chk(wz == e.wz, {e.req, " wz at fetch"}, wz, e.wz);
               chk(done == e.dn, {e.req, " done with fetch"}, done, e.dn);
            end
         end else if (done) begin
            chk(1'b0, "R6 done without fetch", 1, 0);
         end
      end
   end

   task automatic do_op(input logic [1:0] cls, input logic rf, input logic [15:0] cnt,
                        input logic zf, input logic [15:0] pc, input string req,
                        input bit inject);
      bit rep;
      exp_t e;
      logic [15:0] traj [1:5];
      case (cls)
         2'd0:    rep = (cnt != 16'd0);
         2'd1:    rep = (cnt != 16'd0) && !zf;
         default: rep = (cnt[15:8] != 8'd0);
      endcase
      if (!rf) rep = 1'b0;
      if (rep && cls <= 2'd1) wz_m = pc + 16'd1;
      e.cyc = cyc + (rep ? 6 : 1);
      e.pc  = rep ? 16'(pc - 16'd2) : pc;
      e.wz  = wz_m;
      e.dn  = rep;
      e.req = req;
      sb.push_back(e);
      op_class = cls; rep_form = rf; bc = cnt; zero_flag = zf; pc_in = pc;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (rep) begin
         traj[1] = pc; traj[2] = pc;
         traj[3] = 16'(pc - 16'd1); traj[4] = 16'(pc - 16'd1);
         traj[5] = 16'(pc - 16'd2);
         for (int k = 1; k <= 5; k++) begin
            if (k > 1) @(negedge clk);
            chk(busy == 1'b1, "R6 busy during rewind", busy, 1);
            chk(pc_out == traj[k], "R7 pc trajectory", pc_out, traj[k]);
            if (k == 1) chk(wz == wz_m, "R8 wz at first busy cycle", wz, wz_m);
            if (inject && k == 2) begin
               op_class = 2'd0; rep_form = 1'b1; bc = 16'd1; pc_in = 16'h5555;
               start = 1'b1;
            end else begin
               start = 1'b0;
            end
         end
         @(negedge clk);
         chk(busy == 1'b0, "R6 busy low after five cycles", busy, 0);
      end else begin
         chk(busy == 1'b0, "R9 no busy without repeat", busy, 0);
      end
      @(negedge clk);
      chk(sb.size() == 0, {req, " fetch seen"}, sb.size(), 0);
   endtask

   initial begin
      #(5.0 * 100000);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(busy == 0 && done == 0 && fetch == 0, "R1 reset controls", {busy, done, fetch}, 0);
      chk(pc_out == 0 && wz == 0, "R1 reset registers", pc_out, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // move class
      do_op(2'd0, 1'b1, 16'd3,     1'b0, 16'h1234, "R2 move repeat", 1'b0);
      do_op(2'd0, 1'b1, 16'd0,     1'b0, 16'h2000, "R2 move count zero", 1'b0);
      do_op(2'd0, 1'b1, 16'h0100,  1'b1, 16'h3000, "R2 move high count", 1'b0);
      // search class
      do_op(2'd1, 1'b1, 16'd5,     1'b0, 16'h4000, "R3 search repeat", 1'b0);
      do_op(2'd1, 1'b1, 16'd5,     1'b1, 16'h4100, "R3 search match stops", 1'b0);
      do_op(2'd1, 1'b1, 16'd0,     1'b0, 16'h4200, "R3 search count zero", 1'b0);
      // I/O classes: wz untouched
      do_op(2'd2, 1'b1, 16'h0100,  1'b0, 16'h5000, "R4 input repeat", 1'b0);
      do_op(2'd3, 1'b1, 16'h00FF,  1'b0, 16'h5100, "R4 output low byte ignored", 1'b0);
      do_op(2'd3, 1'b1, 16'h0200,  1'b1, 16'h5200, "R4 output repeat", 1'b0);
      do_op(2'd2, 1'b1, 16'h00FF,  1'b0, 16'h5300, "R4 input low byte ignored", 1'b0);
      // non-repeating forms
      do_op(2'd0, 1'b0, 16'd9,     1'b0, 16'h6000, "R5 single move", 1'b0);
      do_op(2'd2, 1'b0, 16'hFF00,  1'b0, 16'h6100, "R5 single input", 1'b0);
      // wrap
      do_op(2'd0, 1'b1, 16'd1,     1'b0, 16'h0001, "R7 pc wrap low", 1'b0);
      do_op(2'd1, 1'b1, 16'd1,     1'b0, 16'hFFFF, "R8 wz wrap high", 1'b0);
      // strobe while busy
      do_op(2'd2, 1'b1, 16'h0300,  1'b0, 16'h7000, "R10 strobe while busy", 1'b1);
      repeat (4) @(negedge clk);
      chk(sb.size() == 0, "R10 queue drained", sb.size(), 0);
      chk(wz == wz_m, "R8 final wz", wz, wz_m);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule